// File: doc/BRIEF.md
# Decode-Stage Branch Hazard Unit

This unit guards the operand comparator of a five-stage, in-order pipeline that resolves conditional branches in the decode stage. A branch in decode names two source registers. The unit compares them with the destination registers of the instructions in the execute, memory and write-back stages. If a producer's result cannot reach decode in time, it stalls the branch. If the result is already in a pipeline register, it picks that register as the comparator's operand. When the branch resolves as taken, it discards the instruction fetched behind it.

The unit is purely combinational from its stage inputs, so the number of stall cycles follows from how producers advance. A load directly ahead of the branch holds it for two cycles. An ALU producer directly ahead, or a load two ahead, holds it for one cycle. While `stall` is high, the surrounding pipeline holds the PC and the fetch/decode register and writes an all-zero control bubble into decode/execute. A taken branch with `flush` high zeroes the control fields of the fetched instruction. `clk` and `rst_n` only time the embedded checks.

Top module: `branch_hazard_unit`

## Requirements
- R1: With `id_branch` low, `stall` and `flush` are 0 and both forward selects are 2'b00, whatever the stage inputs are.
- R2: A branch source that matches the destination of a valid, writing, non-load instruction in execute raises `stall`.
- R3: A branch source that matches a valid, writing, non-load producer in memory selects 2'b01 (memory-stage result) on that operand's select, with no stall.
- R4: A branch source that matches a valid, writing producer in write-back (load or ALU) selects 2'b10 (write-back result), with no stall.
- R5: A matching load in execute raises `stall`, and a matching load in memory also raises `stall`. A load directly ahead therefore costs two stall cycles, and a load two ahead costs one.
- R6: `flush` is 1 exactly when a branch is in decode, `id_taken` is 1 and `stall` is 0.
- R7: Register 0 never creates a hazard or a forward. A producer with its valid or register-write bit clear is ignored.
- R8: When both memory and write-back match the same source, the memory stage wins (2'b01).
- R9: Operand A (`id_rs`, `fwd_a`) and operand B (`id_rt`, `fwd_b`) are resolved independently. A hazard on either operand stalls the branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded checks |
| rst_n | input | 1 | Active-low reset, disables the checks |
| id_branch | input | 1 | Branch instruction in decode |
| id_taken | input | 1 | Decode comparator result: branch taken |
| id_rs | input | 5 | Branch source register A |
| id_rt | input | 5 | Branch source register B |
| ex_valid | input | 1 | Execute stage holds an instruction |
| ex_regwrite | input | 1 | Execute instruction writes a register |
| ex_memread | input | 1 | Execute instruction is a load |
| ex_rd | input | 5 | Execute destination register |
| mem_valid | input | 1 | Memory stage holds an instruction |
| mem_regwrite | input | 1 | Memory instruction writes a register |
| mem_memread | input | 1 | Memory instruction is a load |
| mem_rd | input | 5 | Memory destination register |
| wb_valid | input | 1 | Write-back stage holds an instruction |
| wb_regwrite | input | 1 | Write-back instruction writes a register |
| wb_rd | input | 5 | Write-back destination register |
| stall | output | 1 | Hold PC and fetch/decode, bubble decode/execute |
| flush | output | 1 | Zero control of the fetched instruction |
| fwd_a | output | 2 | Operand A source: 00 file, 01 memory, 10 write-back |
| fwd_b | output | 2 | Operand B source: 00 file, 01 memory, 10 write-back |

## Verification
Some rules are checked on every cycle: a flush never coincides with a stall, a select never takes the unused code 2'b11, register 0 never forwards, and an idle decode stage produces no activity. Other behaviour only the bench's scenarios can show. These cover the exact stall counts as a load or ALU producer walks down the pipeline, memory-over-write-back priority, the independence of the two operands, and the way a disabled producer is ignored.

// File: rtl/branch_hazard_unit.sv
module branch_hazard_unit #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             id_branch,
  input  logic             id_taken,
  input  logic [REG_W-1:0] id_rs,
  input  logic [REG_W-1:0] id_rt,
  input  logic             ex_valid,
  input  logic             ex_regwrite,
  input  logic             ex_memread,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             mem_valid,
  input  logic             mem_regwrite,
  input  logic             mem_memread,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             wb_valid,
  input  logic             wb_regwrite,
  input  logic [REG_W-1:0] wb_rd,
  output logic             stall,
  output logic             flush,
  output logic [1:0]       fwd_a,
  output logic [1:0]       fwd_b
);

  localparam logic [1:0] SEL_FILE = 2'b00;
  localparam logic [1:0] SEL_MEM  = 2'b01;
  localparam logic [1:0] SEL_WB   = 2'b10;
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic ex_wr, mem_wr, wb_wr;
  logic ex_a, ex_b, mem_a, mem_b, wb_a, wb_b;
  logic hold_a, hold_b;

  assign ex_wr  = ex_valid  & ex_regwrite  & (ex_rd  != ZERO_REG);
  assign mem_wr = mem_valid & mem_regwrite & (mem_rd != ZERO_REG);
  assign wb_wr  = wb_valid  & wb_regwrite  & (wb_rd  != ZERO_REG);

  assign ex_a  = ex_wr  & (ex_rd  == id_rs);
  assign ex_b  = ex_wr  & (ex_rd  == id_rt);
  assign mem_a = mem_wr & (mem_rd == id_rs);
  assign mem_b = mem_wr & (mem_rd == id_rt);
  assign wb_a  = wb_wr  & (wb_rd  == id_rs);
  assign wb_b  = wb_wr  & (wb_rd  == id_rt);

  assign hold_a = ex_a | (mem_a & mem_memread);
  assign hold_b = ex_b | (mem_b & mem_memread);

  assign stall = id_branch & (hold_a | hold_b);
  assign flush = id_branch & id_taken & ~stall;

  always_comb begin
    fwd_a = SEL_FILE;
    fwd_b = SEL_FILE;
    if (id_branch) begin
      if (mem_a)     fwd_a = mem_memread ? SEL_FILE : SEL_MEM;
      else if (wb_a) fwd_a = SEL_WB;
      if (mem_b)     fwd_b = mem_memread ? SEL_FILE : SEL_MEM;
      else if (wb_b) fwd_b = SEL_WB;
    end
  end

  // R6: flush and stall are exclusive
  a_r6_no_flush_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !stall);

  // R3, R4: unused select code never appears
  a_r3_fwd_a_legal: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_a != 2'b11);
  a_r4_fwd_b_legal: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_b != 2'b11);

  // R7: register 0 is never forwarded
  a_r7_zero_a: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rs == ZERO_REG) |-> (fwd_a == SEL_FILE));
  a_r7_zero_b: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rt == ZERO_REG) |-> (fwd_b == SEL_FILE));

  // R1: idle decode stage is silent
  a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !id_branch |-> (!stall && !flush && fwd_a == SEL_FILE && fwd_b == SEL_FILE));

endmodule

// File: tb/tb_branch_hazard_unit.sv
`timescale 1ns/1ps
module tb_branch_hazard_unit;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic id_branch, id_taken;
  logic [4:0] id_rs, id_rt;
  logic ex_valid, ex_regwrite, ex_memread;
  logic [4:0] ex_rd;
  logic mem_valid, mem_regwrite, mem_memread;
  logic [4:0] mem_rd;
  logic wb_valid, wb_regwrite;
  logic [4:0] wb_rd;
  logic stall, flush;
  logic [1:0] fwd_a, fwd_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [5:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  branch_hazard_unit dut (
    .clk(clk), .rst_n(rst_n),
    .id_branch(id_branch), .id_taken(id_taken), .id_rs(id_rs), .id_rt(id_rt),
    .ex_valid(ex_valid), .ex_regwrite(ex_regwrite), .ex_memread(ex_memread), .ex_rd(ex_rd),
    .mem_valid(mem_valid), .mem_regwrite(mem_regwrite), .mem_memread(mem_memread), .mem_rd(mem_rd),
    .wb_valid(wb_valid), .wb_regwrite(wb_regwrite), .wb_rd(wb_rd),
    .stall(stall), .flush(flush), .fwd_a(fwd_a), .fwd_b(fwd_b)
  );

  // stage code: {valid, regwrite, memread, rd[4:0]}
  function automatic logic [7:0] alu(input logic [4:0] r); return {3'b110, r}; endfunction
  function automatic logic [7:0] ld(input logic [4:0] r);  return {3'b111, r}; endfunction
  localparam logic [7:0] NOP = 8'h00;

  task automatic drive(input logic br, input logic tk, input logic [4:0] rs, input logic [4:0] rt,
                       input logic [7:0] ex, input logic [7:0] mem, input logic [7:0] wb,
                       input logic e_st, input logic e_fl, input logic [1:0] e_fa,
                       input logic [1:0] e_fb, input string tag);
    @(negedge clk);
    id_branch = br; id_taken = tk; id_rs = rs; id_rt = rt;
    {ex_valid, ex_regwrite, ex_memread, ex_rd} = ex;
    {mem_valid, mem_regwrite, mem_memread, mem_rd} = mem;
    {wb_valid, wb_regwrite} = wb[7:6]; wb_rd = wb[4:0];
    exp_q.push_back({e_st, e_fl, e_fa, e_fb});
    tag_q.push_back(tag);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [5:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if ({stall, flush, fwd_a, fwd_b} !== e) begin
          errors++;
          $display("FAIL %s: got stall=%b flush=%b fa=%b fb=%b, expected stall=%b flush=%b fa=%b fb=%b",
                   t, stall, flush, fwd_a, fwd_b, e[5], e[4], e[3:2], e[1:0]);
        end
      end
    end
  end

  initial begin : watchdog
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    drive(0,0,0,0, NOP,NOP,NOP, 0,0,2'b00,2'b00, "reset R1");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // R1: no branch, busy stages
    drive(0,1,5'd3,5'd4, alu(3),ld(4),alu(3), 0,0,2'b00,2'b00, "R1 idle");
    // R2: ALU in EX, then it moves to MEM -> forward
    drive(1,1,5'd3,5'd9, alu(3),NOP,NOP, 1,0,2'b00,2'b00, "R2 ex alu stall");
    drive(1,1,5'd3,5'd9, NOP,alu(3),NOP, 0,1,2'b01,2'b00, "R3 mem alu fwd");
    // R4: ALU in WB, load in WB
    drive(1,0,5'd7,5'd8, NOP,NOP,alu(7), 0,0,2'b10,2'b00, "R4 wb alu fwd");
    drive(1,0,5'd7,5'd8, NOP,NOP,ld(8), 0,0,2'b00,2'b10, "R4 wb load fwd");
    // R5: load walking down from EX: two stalls then forward
    drive(1,1,5'd5,5'd0, ld(5),NOP,NOP, 1,0,2'b00,2'b00, "R5 load ex stall 1");
    drive(1,1,5'd5,5'd0, NOP,ld(5),NOP, 1,0,2'b00,2'b00, "R5 load mem stall 2");
    drive(1,1,5'd5,5'd0, NOP,NOP,ld(5), 0,1,2'b10,2'b00, "R5 load wb fwd");
    // R6: taken without hazard flushes; not taken does not
    drive(1,1,5'd1,5'd2, NOP,NOP,NOP, 0,1,2'b00,2'b00, "R6 taken flush");
    drive(1,0,5'd1,5'd2, NOP,NOP,NOP, 0,0,2'b00,2'b00, "R6 not taken");
    // R7: register 0 and disabled producers
    drive(1,1,5'd0,5'd0, alu(0),ld(0),alu(0), 0,1,2'b00,2'b00, "R7 reg zero");
    drive(1,1,5'd6,5'd6, {3'b010,5'd6},{3'b101,5'd6},{3'b000,5'd6}, 0,1,2'b00,2'b00, "R7 disabled");
    // R8: MEM beats WB
    drive(1,0,5'd9,5'd9, NOP,alu(9),alu(9), 0,0,2'b01,2'b01, "R8 priority");
    // R9: independent operands, B hazard stalls
    drive(1,0,5'd10,5'd11, NOP,alu(10),alu(11), 0,0,2'b01,2'b10, "R9 split fwd");
    drive(1,1,5'd10,5'd11, alu(11),NOP,alu(10), 1,0,2'b10,2'b00, "R9 b stall");
    drive(1,1,5'd12,5'd13, NOP,ld(13),NOP, 1,0,2'b00,2'b00, "R9 b load stall");
    drive(0,0,0,0, NOP,NOP,NOP, 0,0,2'b00,2'b00, "R1 final");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule